// File: doc/BRIEF.md
# Eight-Function Integer ALU

A purely combinational arithmetic logic unit for two N-bit operands, `W` bits wide (32 by default). A 3-bit function code picks one of eight slots. The top bit of the code decides whether the second operand reaches the datapath as it is or with every bit inverted. The two low bits pick which of four sources drives the result: bitwise AND, bitwise OR, the adder sum, or a set-less-than bit.

The unit has one ripple adder. Its carry-in is tied to the same invert bit, so one add path serves addition, subtraction and the set-less-than compare. Along with the result, the unit drives two flags:

- a zero flag, raised when every result bit is clear;
- a signed-overflow flag for the add and subtract codes.

There is no clock, no state and no handshake. The result settles within the same cycle in which the operands and the code are presented. A surrounding datapath samples the outputs when it needs them.

Top module: `eightfn_alu`

## Requirements
- R1: Code 000 drives `y` to `a & b`, and code 001 drives `y` to `a | b`.
- R2: Code 100 drives `y` to `a & ~b`, and code 101 drives `y` to `a | ~b`.
- R3: Code 010 drives `y` to `a + b`, modulo 2^W.
- R4: Code 110 drives `y` to `a - b`, modulo 2^W (two's complement).
- R5: Code 111 drives `y[0]` to the most significant bit of the W-bit difference `a - b` and clears `y[W-1:1]`. The compare is not corrected for overflow: with a = 0x80000000 and b = 1 the result is 0.
- R6: Code 011 is reserved and drives `y` to all zeros for any operands.
- R7: `zero` is 1 exactly when all W bits of `y` are 0, under every code, including the reserved code.
- R8: Under code 010, `ovf` is 1 exactly when `a` and `b` have the same sign bit and the sum's sign bit differs from it. Under code 110, `ovf` is 1 exactly when the sign bits of `a` and `b` differ and the difference's sign bit differs from that of `a`.
- R9: `ovf` is 0 under codes 000, 001, 011, 100, 101 and 111, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand; inverted when fn[2] is 1 |
| fn | input | 3 | Function code: bit 2 inverts b and sets the carry-in, bits 1:0 pick AND/OR/sum/less-than |
| y | output | W | Result |
| zero | output | 1 | High when y is all zeros |
| ovf | output | 1 | Signed overflow of the add or subtract |

## Verification
The hardest outcomes to reach from the ports are the signed-overflow boundaries and a set-less-than whose difference has wrapped. Uniform random operands almost never land on them. The stimulus therefore has three parts:

- directed vectors at the extreme values (largest positive plus one, most negative minus one, most negative compared with one);
- random operands whose sign bits are forced to chosen pairs, so each overflow case and the wrapped compare appear often;
- equal-operand subtracts, which exercise the zero flag from the arithmetic path rather than the logic path.

// File: rtl/eightfn_alu_pkg.sv
package eightfn_alu_pkg;

  typedef enum logic [2:0] {
    FN_AND  = 3'b000,
    FN_OR   = 3'b001,
    FN_ADD  = 3'b010,
    FN_RSVD = 3'b011,
    FN_ANDN = 3'b100,
    FN_ORN  = 3'b101,
    FN_SUB  = 3'b110,
    FN_SLT  = 3'b111
  } alu_fn_e;

  typedef enum logic [1:0] {
    SRC_AND = 2'd0,
    SRC_OR  = 2'd1,
    SRC_SUM = 2'd2,
    SRC_SLT = 2'd3
  } alu_src_e;

  // Codes whose overflow flag is meaningful
  function automatic logic fn_reports_ovf(alu_fn_e f);
    return (f == FN_ADD) || (f == FN_SUB);
  endfunction

endpackage

// File: rtl/eightfn_operand_sel.sv
module eightfn_operand_sel #(
  parameter int W = 32
) (
  input  logic [W-1:0] b_in,
  input  logic         invert,
  output logic [W-1:0] b_eff
);
  always_comb b_eff = invert ? ~b_in : b_in;
endmodule

// File: rtl/eightfn_ripple_adder.sv
module eightfn_ripple_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] z,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_into_msb,
  output logic         c_out
);
  logic [W:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = x[i] ^ z[i] ^ carry[i];
    assign carry[i+1] = (x[i] & z[i]) | (carry[i] & (x[i] ^ z[i]));
  end

  assign c_into_msb = carry[W-1];
  assign c_out      = carry[W];
endmodule

// File: rtl/eightfn_logic_unit.sv
module eightfn_logic_unit #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] z,
  output logic [W-1:0] and_out,
  output logic [W-1:0] or_out
);
  always_comb begin
    and_out = x & z;
    or_out  = x | z;
  end
endmodule

// File: rtl/eightfn_result_sel.sv
module eightfn_result_sel
  import eightfn_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2:0]   fn,
  input  logic [W-1:0] and_in,
  input  logic [W-1:0] or_in,
  input  logic [W-1:0] sum_in,
  input  logic         c_into_msb,
  input  logic         c_out,
  output logic [W-1:0] y,
  output logic         zero,
  output logic         ovf
);
  localparam int PadW = W - 1;

  alu_fn_e  code;
  alu_src_e src;
  logic     raw_ovf;

  always_comb begin
    code    = alu_fn_e'(fn);
    src     = alu_src_e'(fn[1:0]);
    raw_ovf = c_into_msb ^ c_out;
    unique case (src)
      SRC_AND: y = and_in;
      SRC_OR:  y = or_in;
      SRC_SUM: y = sum_in;
      default: y = (code == FN_RSVD) ? '0 : {{PadW{1'b0}}, sum_in[W-1]};
    endcase
    zero = ~|y;
    ovf  = fn_reports_ovf(code) & raw_ovf;
  end
endmodule

// File: rtl/eightfn_alu.sv
module eightfn_alu
  import eightfn_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   fn,
  output logic [W-1:0] y,
  output logic         zero,
  output logic         ovf
);
  logic [W-1:0] b_eff, and_w, or_w, sum_w;
  logic         c_msb, c_top;

  eightfn_operand_sel #(.W(W)) u_opsel (
    .b_in(b), .invert(fn[2]), .b_eff(b_eff)
  );

  eightfn_logic_unit #(.W(W)) u_logic (
    .x(a), .z(b_eff), .and_out(and_w), .or_out(or_w)
  );

  eightfn_ripple_adder #(.W(W)) u_add (
    .x(a), .z(b_eff), .cin(fn[2]), .sum(sum_w),
    .c_into_msb(c_msb), .c_out(c_top)
  );

  eightfn_result_sel #(.W(W)) u_sel (
    .fn(fn), .and_in(and_w), .or_in(or_w), .sum_in(sum_w),
    .c_into_msb(c_msb), .c_out(c_top),
    .y(y), .zero(zero), .ovf(ovf)
  );
endmodule

// File: rtl/eightfn_alu_chk.sv
module eightfn_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [2:0]   fn,
  input logic [W-1:0] y,
  input logic         zero,
  input logic         ovf
);
  logic known;

  always_comb begin
    known = !$isunknown({a, b, fn, y, zero, ovf});
    if (known) begin
      a_r7_zero_flag: assert (zero == (y == '0))
        else $error("R7 zero flag disagrees with result");
      a_r9_no_overflow: assert ((fn == 3'b010) || (fn == 3'b110) || !ovf)
        else $error("R9 overflow raised on non-arith code");
      a_r6_reserved_zero: assert ((fn != 3'b011) || (y == '0))
        else $error("R6 reserved code gave nonzero result");
      a_r5_slt_upper_clear: assert ((fn != 3'b111) || (y[W-1:1] == '0))
        else $error("R5 set-less-than upper bits not clear");
      a_r8_add_overflow: assert ((fn != 3'b010) ||
          (ovf == ((a[W-1] == b[W-1]) && (y[W-1] != a[W-1]))))
        else $error("R8 add overflow mismatch");
      a_r8_sub_overflow: assert ((fn != 3'b110) ||
          (ovf == ((a[W-1] != b[W-1]) && (y[W-1] != a[W-1]))))
        else $error("R8 subtract overflow mismatch");
    end
  end
endmodule

bind eightfn_alu eightfn_alu_chk #(.W(W)) u_chk (
  .a(a), .b(b), .fn(fn), .y(y), .zero(zero), .ovf(ovf)
);

// File: tb/eightfn_alu_bench.sv
module eightfn_alu_bench;
  localparam int W = 32;
  localparam logic [W-1:0] MAXP = 32'h7FFF_FFFF;
  localparam logic [W-1:0] MINN = 32'h8000_0000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a, b, y;
  logic [2:0]   fn;
  logic         zero, ovf;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  eightfn_alu #(.W(W)) u_eightfn_alu (
    .a(a), .b(b), .fn(fn), .y(y), .zero(zero), .ovf(ovf)
  );

  function automatic logic [W-1:0] exp_y(logic [2:0] f, logic [W-1:0] x, logic [W-1:0] z);
    logic [W-1:0] d;
    d = x - z;
    case (f)
      3'b000: return x & z;
      3'b001: return x | z;
      3'b010: return x + z;
      3'b100: return x & ~z;
      3'b101: return x | ~z;
      3'b110: return d;
      3'b111: return {{(W-1){1'b0}}, d[W-1]};
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_ovf(logic [2:0] f, logic [W-1:0] x, logic [W-1:0] z);
    logic [W-1:0] s, d;
    s = x + z;
    d = x - z;
    if (f == 3'b010) return (x[W-1] == z[W-1]) && (s[W-1] != x[W-1]);
    if (f == 3'b110) return (x[W-1] != z[W-1]) && (d[W-1] != x[W-1]);
    return 1'b0;
  endfunction

  function automatic string ytag(logic [2:0] f);
    case (f)
      3'b000, 3'b001: return "R1";
      3'b100, 3'b101: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run(logic [2:0] f, logic [W-1:0] x, logic [W-1:0] z);
    logic [W-1:0] ey;
    logic eo;
    @(negedge clk);
    fn = f; a = x; b = z;
    #1;
    ey = exp_y(f, x, z);
    eo = exp_ovf(f, x, z);
    n_chk++;
    if (y !== ey) begin
      n_fail++;
      $display("FAIL %s fn=%b a=%h b=%h y=%h expected %h", ytag(f), f, x, z, y, ey);
    end
    n_chk++;
    if (zero !== (ey == '0)) begin
      n_fail++;
      $display("FAIL R7 fn=%b a=%h b=%h zero=%b expected %b", f, x, z, zero, ey == '0);
    end
    n_chk++;
    if (ovf !== eo) begin
      n_fail++;
      $display("FAIL %s fn=%b a=%h b=%h ovf=%b expected %b",
               ((f == 3'b010) || (f == 3'b110)) ? "R8" : "R9", f, x, z, ovf, eo);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    a = '0; b = '0; fn = 3'b000;
    // R1 / R2 directed patterns
    run(3'b000, 32'hF0F0_1234, 32'h0FF0_FFFF);
    run(3'b001, 32'hF000_0000, 32'h0000_000F);
    run(3'b100, 32'hDEAD_BEEF, 32'hFFFF_FFFF);  // R2 result zero
    run(3'b101, 32'h0000_0000, 32'hFFFF_FFFF);  // R2 result zero
    // R3 / R8 add overflow corners
    run(3'b010, MAXP, 32'd1);
    run(3'b010, MINN, MINN);
    run(3'b010, 32'hFFFF_FFFF, 32'd1);          // wraps, no signed ovf, zero
    // R4 / R8 subtract corners
    run(3'b110, MINN, 32'd1);
    run(3'b110, MAXP, 32'hFFFF_FFFF);
    run(3'b110, 32'h1234_5678, 32'h1234_5678);  // R7 zero from arithmetic
    // R5 set-less-than, including the wrapped case
    run(3'b111, 32'hFFFF_FFFB, 32'd3);
    run(3'b111, 32'd3, 32'hFFFF_FFFB);
    run(3'b111, 32'd7, 32'd7);
    run(3'b111, MINN, 32'd1);                   // R5 uncorrected: 0
    // R6 reserved code, R9 no overflow
    run(3'b011, MAXP, 32'd1);
    run(3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // Random with steered sign bits
    for (int i = 0; i < 4000; i++) begin
      logic [W-1:0] x, z;
      logic [2:0] f;
      x = $urandom;
      z = $urandom;
      f = 3'($urandom_range(7, 0));
      if (i % 4 == 1) begin x[W-1] = 1'b0; z[W-1] = f[2]; end
      if (i % 4 == 2) begin x[W-1] = 1'b1; z[W-1] = ~f[2]; end
      if (i % 16 == 3) z = x;
      run(f, x, z);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule